// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block takes one request from a host (an opcode, an optional column and an optional page address, each with its own valid flag) and plays it out as write cycles on a small-page NAND bus. It drives the command-latch and address-latch strobes, the active-low chip enable, the active-low write strobe and a 16-bit output data bus. After the command and address phase it either finishes at once or waits for the device's ready indication. The wait depends on the opcode.

For a program-setup request the block first writes the pointer command that selects the page region holding the column, and it rebases the column inside that region. For reads that carry a page address it keeps chip enable low from the upper page byte until the device is ready or the wait gives up. This stops the device from dropping the read while the bus is quiet. Every delay is a count of clock cycles derived from `CLK_MHZ`.

Top module: `nand_cmd_seq`

## Requirements
- R1: Out of reset and while `busy` is 0, `nce`=1, `nwe`=1, `cle`=0, `ale`=0 and `done`=0.
- R2: For opcode 0x80 a pointer command goes out first. With column >= `PAGE_BYTES` the pointer is 0x50 and the column loses `PAGE_BYTES`. With column < 256 the pointer is 0x00. Otherwise the pointer is 0x01 and the column loses 256.
- R3: Bus writes go out in this order: pointer (if any), opcode, column low byte (if the column is valid), page[7:0], page[15:8] (both only if the page is valid). `cle`=1 marks pointer and opcode writes. `ale`=1 marks address writes.
- R4: A further address write carrying page[19:16] in the low nibble follows only when `dev_mib` > 32.
- R5: With `bus16`=1 the rebased column is shifted right by one before it is sent. Every written byte sits zero-extended in `dq_out[15:0]`.
- R6: For opcodes 0x00, 0x01 and 0x50 with a valid page, `nce` stays low from the upper page write until the wait ends, then returns high. For other requests `nce` is high outside bus writes.
- R7: Opcodes 0x80, 0x10, 0x60, 0xD0 and 0x70 raise `done` for one cycle without sampling ready.
- R8: Any request that waits spends at least 100 ns of cycles after its last write (and after any settle time) before it samples ready, which is `status_in[0]`=1.
- R9: A read with a valid page that sees no ready within 30 us finishes with `done` and `timeout`=1. Every other waiting request, 0xFF included, waits for ready with no limit.
- R10: After the last address write, the block waits at least 1 us before finishing or sampling ready. A request with no address write skips this wait.
- R11: Every `nwe` low pulse lasts exactly `WE_CYC` cycles and is followed by at least `WE_CYC` high cycles. `cle` and `ale` are never both 1, and `nwe` is low only while `nce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_cmd | input | 8 | Opcode |
| req_col | input | COL_W | Column address |
| req_col_vld | input | 1 | Column address present |
| req_page | input | 20 | Page address |
| req_page_vld | input | 1 | Page address present |
| bus16 | input | 1 | Device bus is 16 bits wide |
| dev_mib | input | 16 | Device capacity in MiB |
| status_in | input | 8 | Status word, bit 0 is ready |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write strobe, active low |
| dq_out | output | 16 | Output data bus |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| timeout | output | 1 | Last request's wait expired; cleared by the next request |

## Verification
Program-setup requests are sent with columns in the spare area, in the upper half and in the lower half of the page. The pointer byte and the rebased column together show which region was chosen.

The same reads are run at 32 MiB and at 64 MiB to show that the fourth address write depends only on capacity. A 16-bit bus run separates shifting the column from shifting the whole byte.

Done latency is measured from the last write rise for:
- commands with no address,
- commands with an address,
- reset,
- reads.

These measurements separate the no-wait, settle and tWB cases. A read that never gets ready, set against a reset that waits past that limit, tells the timed wait from the unlimited one. Sampling `nce` in the quiet gap of a read and of a program shows whether chip enable is held.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int SLOTS  = 6;    // pointer, opcode, column, page lo, page hi, page top
    localparam int PAGE_W = 20;

    localparam logic [7:0] OP_RD_LO  = 8'h00;
    localparam logic [7:0] OP_RD_HI  = 8'h01;
    localparam logic [7:0] OP_RD_SP  = 8'h50;
    localparam logic [7:0] OP_PROG   = 8'h80;
    localparam logic [7:0] OP_CONF   = 8'h10;
    localparam logic [7:0] OP_ER_A   = 8'h60;
    localparam logic [7:0] OP_ER_B   = 8'hD0;
    localparam logic [7:0] OP_STAT   = 8'h70;

    typedef enum logic [2:0] {
        S_IDLE, S_WLOW, S_WHIGH, S_SETTLE, S_TWB, S_POLL
    } seq_state_t;

    typedef enum logic [1:0] {
        W_NONE, W_TIMED, W_FOREVER
    } wait_kind_t;

    typedef struct packed {
        logic [SLOTS-1:0]      en;
        logic [SLOTS-1:0][7:0] bytes;
        wait_kind_t            wkind;
        logic                  hold;
        logic                  any_addr;
    } seq_plan_t;

endpackage

// File: rtl/nand_seq_plan.sv
module nand_seq_plan
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 10
) (
    input  logic [7:0]        cmd,
    input  logic [COL_W-1:0]  col,
    input  logic              col_vld,
    input  logic [PAGE_W-1:0] page,
    input  logic              page_vld,
    input  logic              bus16,
    input  logic [15:0]       dev_mib,
    output seq_plan_t         plan
);
    localparam logic [COL_W-1:0] PG_LIM   = COL_W'(PAGE_BYTES);
    localparam logic [COL_W-1:0] HALF_LIM = COL_W'(256);

    logic             is_prog, is_read;
    logic [7:0]       ptr_byte;
    logic [COL_W-1:0] col_rebased;
    logic [7:0]       col_byte;

    always_comb begin
        is_prog = (cmd == OP_PROG);
        is_read = (cmd == OP_RD_LO) || (cmd == OP_RD_HI) || (cmd == OP_RD_SP);

        ptr_byte    = OP_RD_LO;
        col_rebased = col;
        if (is_prog) begin
            if (col >= PG_LIM) begin
                ptr_byte    = OP_RD_SP;
                col_rebased = col - PG_LIM;
            end else if (col >= HALF_LIM) begin
                ptr_byte    = OP_RD_HI;
                col_rebased = col - HALF_LIM;
            end
        end
        col_byte = bus16 ? 8'(col_rebased >> 1) : 8'(col_rebased);

        plan.en[0]    = is_prog;
        plan.en[1]    = 1'b1;
        plan.en[2]    = col_vld;
        plan.en[3]    = page_vld;
        plan.en[4]    = page_vld;
        plan.en[5]    = page_vld && (dev_mib > 16'd32);
        plan.bytes[0] = ptr_byte;
        plan.bytes[1] = cmd;
        plan.bytes[2] = col_byte;
        plan.bytes[3] = page[7:0];
        plan.bytes[4] = page[15:8];
        plan.bytes[5] = {4'h0, page[19:16]};
        plan.hold     = is_read && page_vld;
        plan.any_addr = col_vld || page_vld;

        if (is_prog || cmd == OP_CONF || cmd == OP_ER_A || cmd == OP_ER_B || cmd == OP_STAT)
            plan.wkind = W_NONE;
        else if (is_read && page_vld)
            plan.wkind = W_TIMED;
        else
            plan.wkind = W_FOREVER;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 50,
    parameter int WE_CYC     = 2,
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_cmd,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_col_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_page_vld,
    input  logic              bus16,
    input  logic [15:0]       dev_mib,
    input  logic [7:0]        status_in,
    output logic              cle,
    output logic              ale,
    output logic              nce,
    output logic              nwe,
    output logic [15:0]       dq_out,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    localparam int TWB_CYC    = (CLK_MHZ * 100 + 999) / 1000;
    localparam int SETTLE_CYC = CLK_MHZ;
    localparam int TMO_CYC    = 30 * CLK_MHZ;
    localparam int MAX_CYC    = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam int IDX_W      = $clog2(SLOTS);

    typedef struct packed {
        seq_state_t       state;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        seq_plan_t        plan;
        logic             hold;
        logic             done;
        logic             tmo;
    } seq_regs_t;

    seq_regs_t        q, d;
    seq_plan_t        plan_w;
    logic             nxt_found, to_post, to_finish, on_bus;
    logic [IDX_W-1:0] nxt_idx, first_idx;
    logic             unused_status;

    assign unused_status = ^status_in[7:1];

    nand_seq_plan #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_plan (
        .cmd(req_cmd), .col(req_col), .col_vld(req_col_vld),
        .page(req_page), .page_vld(req_page_vld),
        .bus16(bus16), .dev_mib(dev_mib), .plan(plan_w)
    );

    always_comb begin
        nxt_found = 1'b0;
        nxt_idx   = '0;
        first_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (q.plan.en[i] && IDX_W'(i) > q.idx) begin
                nxt_found = 1'b1;
                nxt_idx   = IDX_W'(i);
            end
            if (plan_w.en[i]) first_idx = IDX_W'(i);
        end

        d         = q;
        d.done    = 1'b0;
        to_post   = 1'b0;
        to_finish = 1'b0;

        case (q.state)
            S_IDLE: if (req_valid) begin
                d.plan  = plan_w;
                d.idx   = first_idx;
                d.state = S_WLOW;
                d.cnt   = CNT_W'(WE_CYC - 1);
                d.tmo   = 1'b0;
            end
            S_WLOW: begin
                if (q.cnt == '0) begin
                    d.state = S_WHIGH;
                    d.cnt   = CNT_W'(WE_CYC - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            S_WHIGH: begin
                if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
                else if (nxt_found) begin
                    d.state = S_WLOW;
                    d.idx   = nxt_idx;
                    d.cnt   = CNT_W'(WE_CYC - 1);
                    if (nxt_idx == IDX_W'(4) && q.plan.hold) d.hold = 1'b1;
                end else if (q.plan.any_addr) begin
                    d.state = S_SETTLE;
                    d.cnt   = CNT_W'(SETTLE_CYC - 1);
                end else to_post = 1'b1;
            end
            S_SETTLE: begin
                if (q.cnt == '0) to_post = 1'b1;
                else d.cnt = q.cnt - 1'b1;
            end
            S_TWB: begin
                if (q.cnt == '0) begin
                    d.state = S_POLL;
                    d.cnt   = CNT_W'(TMO_CYC - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            S_POLL: begin
                if (status_in[0]) to_finish = 1'b1;
                else if (q.plan.wkind == W_TIMED && q.cnt == '0) begin
                    to_finish = 1'b1;
                    d.tmo     = 1'b1;
                end else if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
            end
            default: d.state = S_IDLE;
        endcase

        if (to_post) begin
            if (q.plan.wkind == W_NONE) to_finish = 1'b1;
            else begin
                d.state = S_TWB;
                d.cnt   = CNT_W'(TWB_CYC - 1);
            end
        end
        if (to_finish) begin
            d.state = S_IDLE;
            d.done  = 1'b1;
            d.hold  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign on_bus  = (q.state == S_WLOW) || (q.state == S_WHIGH);
    assign cle     = on_bus && (q.idx <= IDX_W'(1));
    assign ale     = on_bus && (q.idx >= IDX_W'(2));
    assign nwe     = (q.state != S_WLOW);
    assign nce     = !(on_bus || q.hold);
    assign dq_out  = on_bus ? {8'h00, q.plan.bytes[q.idx]} : 16'h0000;
    assign busy    = (q.state != S_IDLE);
    assign done    = q.done;
    assign timeout = q.tmo;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nwe && !cle && !ale && nce)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R11
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !nwe |-> !nce); // R11
    AST_HOLD_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_POLL && q.plan.wkind == W_TIMED) |-> !nce); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> done); // R9
    AST_NO_POLL_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.plan.wkind == W_NONE) |-> (q.state != S_POLL && q.state != S_TWB)); // R7

endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
    localparam int COL_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_cmd = 8'h00;
    logic [COL_W-1:0] req_col = '0;
    logic        req_col_vld = 1'b0;
    logic [19:0] req_page = '0;
    logic        req_page_vld = 1'b0;
    logic        bus16 = 1'b0;
    logic [15:0] dev_mib = 16'd32;
    logic        rdy = 1'b0;
    logic        cle, ale, nce, nwe, busy, done, timeout;
    logic [15:0] dq_out;

    int nchk = 0, nfail = 0, cyc = 0;
    int nlog = 0, lowrun = 0, min_low = 1000, last_rise = 0, done_cyc = 0;
    int minhigh = 1000, highrun = 0;
    logic [15:0] log_dq [16];
    logic        log_cle [16];
    logic        log_ale [16];

    nand_cmd_seq u_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_col(req_col), .req_col_vld(req_col_vld), .req_page(req_page),
        .req_page_vld(req_page_vld), .bus16(bus16), .dev_mib(dev_mib),
        .status_in({7'h00, rdy}), .cle(cle), .ale(ale), .nce(nce), .nwe(nwe),
        .dq_out(dq_out), .busy(busy), .done(done), .timeout(timeout)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!nwe) begin
            if (highrun > 0 && nlog > 0 && highrun < minhigh) minhigh = highrun;
            highrun = 0;
            lowrun  = lowrun + 1;
        end else begin
            if (busy) highrun = highrun + 1;
            if (lowrun > 0) begin
                if (nlog < 16) begin
                    log_dq[nlog]  = dq_out;
                    log_cle[nlog] = cle;
                    log_ale[nlog] = ale;
                end
                nlog = nlog + 1;
                if (lowrun < min_low) min_low = lowrun;
                last_rise = cyc;
            end
            lowrun = 0;
        end
        if (done) done_cyc = cyc;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        nchk++;
        if (act < lim) begin
            nfail++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic chk_lt(input string req, input int act, input int lim);
        nchk++;
        if (act >= lim) begin
            nfail++;
            $display("FAIL %s actual=%0d expected<%0d", req, act, lim);
        end
    endtask

    task automatic start(input logic [7:0] c, input int col, input logic cv,
                         input int page, input logic pv);
        @(negedge clk);
        nlog = 0;
        req_cmd = c; req_col = COL_W'(col); req_col_vld = cv;
        req_page = 20'(page); req_page_vld = pv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, input int limit);
        int n = 0;
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(req, done, 1'b1);
        @(negedge clk);
    endtask

    task automatic chk_byte(input string req, input int i, input logic c,
                            input logic a, input logic [15:0] v);
        chk(req, {log_cle[i], log_ale[i], log_dq[i]}, {c, a, v});
    endtask

    task automatic t_reset;
        chk("R1 idle strobes", {busy, nce, nwe, cle, ale, done}, 6'b011000);
    endtask

    task automatic t_read_hold;
        rdy = 1'b0;
        start(8'h00, 5, 1'b1, 20'h12345, 1'b1);
        for (int n = 0; n < 200 && nlog < 4; n++) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R6 nce held during read wait", {busy, nce}, 2'b10);
        rdy = 1'b1;
        wait_done("R9 read done on ready", 200);
        chk("R9 no timeout", timeout, 1'b0);
        chk("R6 nce released", nce, 1'b1);
        chk("R4 three addr at 32MiB", nlog, 4);
        chk_byte("R3 opcode", 0, 1, 0, 16'h0000);
        chk_byte("R3 column", 1, 0, 1, 16'h0005);
        chk_byte("R3 page lo", 2, 0, 1, 16'h0045);
        chk_byte("R3 page hi", 3, 0, 1, 16'h0023);
    endtask

    task automatic t_big_dev;
        dev_mib = 16'd64; rdy = 1'b1;
        start(8'h01, 16, 1'b1, 20'hABCDE, 1'b1);
        wait_done("R4 done", 300);
        chk("R4 five writes", nlog, 5);
        chk_byte("R4 top page nibble", 4, 0, 1, 16'h000A);
        chk_byte("R3 opcode 01", 0, 1, 0, 16'h0001);
        dev_mib = 16'd32;
    endtask

    task automatic t_pointer;
        start(8'h80, 600, 1'b1, 20'h00077, 1'b1);
        wait_done("R2 spare done", 300);
        chk_byte("R2 spare pointer", 0, 1, 0, 16'h0050);
        chk_byte("R2 program opcode", 1, 1, 0, 16'h0080);
        chk_byte("R2 spare column", 2, 0, 1, 16'h0058);
        start(8'h80, 300, 1'b1, 20'h00077, 1'b1);
        for (int n = 0; n < 200 && nlog < 5; n++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R6 no hold on program", {busy, nce}, 2'b11);
        wait_done("R2 upper done", 300);
        chk_byte("R2 upper pointer", 0, 1, 0, 16'h0001);
        chk_byte("R2 upper column", 2, 0, 1, 16'h002C);
        start(8'h80, 100, 1'b1, 20'h00077, 1'b1);
        wait_done("R2 lower done", 300);
        chk_byte("R2 lower pointer", 0, 1, 0, 16'h0000);
        chk_byte("R2 lower column", 2, 0, 1, 16'h0064);
    endtask

    task automatic t_bus16;
        bus16 = 1'b1;
        start(8'h80, 300, 1'b1, 20'h00001, 1'b1);
        wait_done("R5 done", 300);
        chk_byte("R5 halved column", 2, 0, 1, 16'h0016);
        chk_byte("R5 zero-extended page", 3, 0, 1, 16'h0001);
        bus16 = 1'b0;
    endtask

    task automatic t_nowait;
        rdy = 1'b0;
        start(8'h70, 0, 1'b0, 0, 1'b0);
        wait_done("R7 status done without ready", 40);
        chk("R7 status single write", nlog, 1);
        chk_lt("R10 no settle without address", done_cyc - last_rise, 10);
        start(8'hD0, 0, 1'b0, 0, 1'b0);
        wait_done("R7 erase confirm done", 40);
        start(8'h60, 0, 1'b0, 20'h00321, 1'b1);
        wait_done("R7 erase setup done", 200);
        chk("R3 erase writes", nlog, 3);
        chk_byte("R3 erase page lo", 1, 0, 1, 16'h0021);
        chk_ge("R10 settle after address", done_cyc - last_rise, 50);
    endtask

    task automatic t_twb;
        rdy = 1'b1;
        start(8'hFF, 0, 1'b0, 0, 1'b0);
        wait_done("R8 reset done", 100);
        chk_ge("R8 twb before ready sample", done_cyc - last_rise, 5);
        chk_lt("R10 reset has no settle", done_cyc - last_rise, 50);
        start(8'h00, 1, 1'b1, 20'h00002, 1'b1);
        wait_done("R8 read done", 300);
        chk_ge("R8 settle plus twb on read", done_cyc - last_rise, 55);
    endtask

    task automatic t_timeout;
        rdy = 1'b0;
        start(8'h50, 3, 1'b1, 20'h00007, 1'b1);
        wait_done("R9 read timeout done", 3000);
        chk("R9 timeout flag", timeout, 1'b1);
        chk_ge("R9 waited 30us", done_cyc - last_rise, 1555);
        chk("R6 nce released after timeout", nce, 1'b1);
    endtask

    task automatic t_reset_forever;
        rdy = 1'b0;
        start(8'hFF, 0, 1'b0, 0, 1'b0);
        repeat (3000) @(negedge clk);
        chk("R9 reset still waiting", {busy, timeout}, 2'b10);
        chk("R6 reset wait without hold", nce, 1'b1);
        rdy = 1'b1;
        wait_done("R9 reset done", 100);
        chk("R9 reset no timeout", timeout, 1'b0);
    endtask

    task automatic t_pulses;
        chk("R11 nwe low width", min_low, 2);
        chk_ge("R11 nwe high width", minhigh, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_read_hold;
        t_big_dev;
        t_pointer;
        t_bus16;
        t_nowait;
        t_twb;
        t_timeout;
        t_reset_forever;
        t_pulses;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule